// File: doc/BRIEF.md
# Bucket Accumulation Hazard Scheduler

This block runs the bucket accumulation phase of a windowed multi-scalar sum. Items arrive as a stream while earlier items are still being processed. Each item carries a window digit, which selects a bucket, and an operand. For each item the block reads the running value of its bucket and starts one addition in a fixed-latency adder pipeline. It writes the result back to that bucket when the result comes out. The block only adds; it never multiplies a scalar. Bucket aggregation and final aggregation are later phases and sit outside the block.

The adder accepts one operation per clock and returns the result `LAT` cycles later. A second addition to a bucket that already has one in flight would read a stale value. Such an item is therefore parked in a small waiting buffer, and other work goes to the adder in its place, so the adder stays busy instead of stalling the input on every hazard. A modular integer adder stands in for the real curve adder.

The input is valid/ready. An item transfers on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while the waiting buffer is full, and that holds even for a digit-zero item. The producer must hold the item stable until it transfers and must send nothing after the item that carries `in_last`. The accumulated buckets are read combinationally through `rd_idx`/`rd_data`.

Top module: `bucket_sched`

## Requirements
- R1: After reset every bucket reads zero, `in_ready` is high and `done` is low.
- R2: Every accepted item with a nonzero digit d adds its operand into bucket d modulo `MOD`. Operands are below `MOD`. After `done`, each bucket holds the modular sum of all operands sent to it.
- R3: An item with digit 0 is accepted and dropped. It reaches no adder and changes no bucket, so bucket 0 stays zero.
- R4: At most one addition per bucket is in flight at any time. Back-to-back items to one bucket therefore lose no update.
- R5: Items with pairwise distinct digits are accepted one per cycle with no back-pressure, as long as each digit's bucket has nothing in flight.
- R6: An item whose bucket is busy waits in a `PEND`-entry buffer. `in_ready` drops while that buffer is full, and every item is still counted exactly once.
- R7: When a waiting item's bucket is free, the oldest such item is issued, ahead of any new input. New input issues directly only when no waiting item can go.
- R8: `done` rises only once the `in_last` item has been accepted, the waiting buffer is empty and no addition is in flight. A lone item sent with `in_last` into an idle block raises `done` exactly `LAT` edges after its transfer edge, and its bucket holds the result at that same point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Block can take an item (waiting buffer not full) |
| in_digit | input | $clog2(NBKT) | Window digit, selects the bucket; 0 means no contribution |
| in_operand | input | DATA_W | Operand added into the bucket |
| in_last | input | 1 | Marks the final item of the stream |
| rd_idx | input | $clog2(NBKT) | Bucket index to read |
| rd_data | output | DATA_W | Current value of bucket `rd_idx` |
| done | output | 1 | Accumulation complete |

## Verification
Three things can fall in the same cycle. A waiting item can become issuable on the very cycle a new input arrives for a free bucket. A writeback can retire one bucket while an issue starts another. A new item for the bucket being issued from the buffer can also arrive in that cycle. Bursts of items to one bucket, interleaved with items to other buckets, fill the buffer and force these collisions; randomised streams heavy with repeated digits add more. The bench judges the outcome by comparing every bucket after `done` with a sequential modular sum of the same stream. A lost or doubled update from a wrong choice would show as a mismatch.

// File: rtl/bsched_pkg.sv
package bsched_pkg;
  // modular add of two reduced values, a,b < m
  function automatic logic [63:0] mod_add(input logic [63:0] a, input logic [63:0] b,
                                          input logic [63:0] m);
    logic [64:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, m}) s = s - {1'b0, m};
    return s[63:0];
  endfunction
endpackage

// File: rtl/bsched_pending.sv
module bsched_pending #(
  parameter int NBKT = 16,
  parameter int DATA_W = 32,
  parameter int PEND = 4,
  localparam int DW = $clog2(NBKT),
  localparam int CW = $clog2(PEND + 1),
  localparam int IW = $clog2(PEND)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBKT-1:0]   busy,
  input  logic              push,
  input  logic [DW-1:0]     push_d,
  input  logic [DATA_W-1:0] push_o,
  input  logic              pop,
  output logic              sel_v,
  output logic [DW-1:0]     sel_d,
  output logic [DATA_W-1:0] sel_o,
  output logic              full,
  output logic              empty
);
  logic [DW-1:0]     ent_d [PEND];
  logic [DATA_W-1:0] ent_o [PEND];
  logic [DW-1:0]     nd    [PEND];
  logic [DATA_W-1:0] no    [PEND];
  logic [CW-1:0]     cnt, ncnt;
  logic [IW-1:0]     sel_idx;

  assign full  = (cnt == CW'(PEND));
  assign empty = (cnt == '0);

  // oldest entry whose bucket is idle
  always_comb begin
    sel_v = 1'b0;
    sel_idx = '0;
    for (int i = 0; i < PEND; i++) begin
      if (!sel_v && (CW'(i) < cnt) && !busy[ent_d[i]]) begin
        sel_v = 1'b1;
        sel_idx = IW'(i);
      end
    end
  end
  assign sel_d = ent_d[sel_idx];
  assign sel_o = ent_o[sel_idx];

  always_comb begin
    nd = ent_d;
    no = ent_o;
    ncnt = cnt;
    if (pop) begin
      for (int i = 0; i < PEND - 1; i++) begin
        if (IW'(i) >= sel_idx) begin
          nd[i] = ent_d[i+1];
          no[i] = ent_o[i+1];
        end
      end
      ncnt = ncnt - 1'b1;
    end
    if (push) begin
      nd[ncnt[IW-1:0]] = push_d;
      no[ncnt[IW-1:0]] = push_o;
      ncnt = ncnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < PEND; i++) begin
        ent_d[i] <= '0;
        ent_o[i] <= '0;
      end
    end else begin
      cnt <= ncnt;
      ent_d <= nd;
      ent_o <= no;
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |-> !full);
  // R7
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty && !busy[sel_d]);
endmodule

// File: rtl/bsched_addpipe.sv
module bsched_addpipe #(
  parameter int NBKT = 16,
  parameter int DATA_W = 32,
  parameter int LAT = 238,
  parameter logic [DATA_W-1:0] MOD = 32'hFFFF_FFFB,
  localparam int DW = $clog2(NBKT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_v,
  input  logic [DW-1:0]     in_d,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_v,
  output logic [DW-1:0]     out_d,
  output logic [DATA_W-1:0] out_s
);
  import bsched_pkg::*;
  logic              v_q [LAT];
  logic [DW-1:0]     d_q [LAT];
  logic [DATA_W-1:0] s_q [LAT];
  logic [DATA_W-1:0] sum;

  assign sum = DATA_W'(mod_add(64'(in_a), 64'(in_b), 64'(MOD)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) v_q[i] <= 1'b0;
    end else begin
      v_q[0] <= in_v;
      for (int i = 1; i < LAT; i++) v_q[i] <= v_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    d_q[0] <= in_d;
    s_q[0] <= sum;
    for (int i = 1; i < LAT; i++) begin
      d_q[i] <= d_q[i-1];
      s_q[i] <= s_q[i-1];
    end
  end

  assign out_v = v_q[LAT-1];
  assign out_d = d_q[LAT-1];
  assign out_s = s_q[LAT-1];
endmodule

// File: rtl/bucket_sched.sv
module bucket_sched #(
  parameter int NBKT = 16,
  parameter int DATA_W = 32,
  parameter int LAT = 238,
  parameter int PEND = 4,
  parameter logic [DATA_W-1:0] MOD = 32'hFFFF_FFFB,
  localparam int DW = $clog2(NBKT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_digit,
  input  logic [DATA_W-1:0] in_operand,
  input  logic              in_last,
  input  logic [DW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  logic [DATA_W-1:0] mem [NBKT];
  logic [NBKT-1:0]   busy_q;
  logic              ended_q;

  logic              sel_v, p_full, p_empty;
  logic [DW-1:0]     sel_d;
  logic [DATA_W-1:0] sel_o;
  logic              in_fire, in_zero, direct, push;
  logic              iss_v;
  logic [DW-1:0]     iss_d;
  logic [DATA_W-1:0] iss_o;
  logic              wb_v;
  logic [DW-1:0]     wb_d;
  logic [DATA_W-1:0] wb_s;

  assign in_ready = !p_full;
  assign in_fire  = in_valid && in_ready;
  assign in_zero  = (in_digit == '0);
  // new input goes straight to the adder only if nothing waiting can go
  assign direct   = in_fire && !in_zero && !sel_v && !busy_q[in_digit];
  assign push     = in_fire && !in_zero && !direct;

  assign iss_v = sel_v || direct;
  assign iss_d = sel_v ? sel_d : in_digit;
  assign iss_o = sel_v ? sel_o : in_operand;

  bsched_pending #(.NBKT(NBKT), .DATA_W(DATA_W), .PEND(PEND)) u_pend (
    .clk(clk), .rst_n(rst_n), .busy(busy_q),
    .push(push), .push_d(in_digit), .push_o(in_operand),
    .pop(sel_v), .sel_v(sel_v), .sel_d(sel_d), .sel_o(sel_o),
    .full(p_full), .empty(p_empty)
  );

  bsched_addpipe #(.NBKT(NBKT), .DATA_W(DATA_W), .LAT(LAT), .MOD(MOD)) u_add (
    .clk(clk), .rst_n(rst_n),
    .in_v(iss_v), .in_d(iss_d), .in_a(mem[iss_d]), .in_b(iss_o),
    .out_v(wb_v), .out_d(wb_d), .out_s(wb_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= '0;
      ended_q <= 1'b0;
      for (int i = 0; i < NBKT; i++) mem[i] <= '0;
    end else begin
      if (wb_v) begin
        mem[wb_d] <= wb_s;
        busy_q[wb_d] <= 1'b0;
      end
      if (iss_v) busy_q[iss_d] <= 1'b1;
      if (in_fire && in_last) ended_q <= 1'b1;
    end
  end

  assign rd_data = mem[rd_idx];
  assign done    = ended_q && p_empty && (busy_q == '0);

  // R4
  no_double_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_v |-> !busy_q[iss_d]);
  // R4
  wb_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_v |-> busy_q[wb_d]);
  // R3
  zero_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_zero && !sel_v |-> !iss_v);
  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !iss_v && !wb_v);
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !in_valid |=> done);
endmodule

// File: tb/bucket_sched_bench.sv
module bucket_sched_bench;
  localparam int NBKT = 16;
  localparam int DW = 4;
  localparam int LAT = 238;
  localparam int PEND = 4;
  localparam longint MODV = 64'hFFFF_FFFB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic in_ready, done;
  logic [DW-1:0] in_digit = '0, rd_idx = '0;
  logic [31:0] in_operand = '0, rd_data;

  int tests = 0, fails = 0, stalls = 0;
  longint refb [NBKT];
  logic [31:0] lfsr = 32'h1234_5678;

  always #2 clk = ~clk;

  bucket_sched #(.NBKT(NBKT), .DATA_W(32), .LAT(LAT), .PEND(PEND)) u_bucket_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_digit(in_digit), .in_operand(in_operand), .in_last(in_last),
    .rd_idx(rd_idx), .rd_data(rd_data), .done(done));

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 0; in_last = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NBKT; i++) refb[i] = 0;
    stalls = 0;
  endtask

  task automatic send(input int d, input longint op, input bit last);
    in_valid = 1; in_digit = DW'(d); in_operand = 32'(op); in_last = last;
    while (!in_ready) begin stalls++; @(negedge clk); end
    @(negedge clk);
    if (d != 0) refb[d] = (refb[d] + op) % MODV;
  endtask

  task automatic idle();
    in_valid = 0; in_last = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check(req, done, 1);
  endtask

  task automatic check_buckets(input string req);
    for (int i = 0; i < NBKT; i++) begin
      rd_idx = DW'(i); #0.1;
      check(req, rd_data, refb[i]);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic t_reset();
    do_reset();
    check("R1 ready", in_ready, 1);
    check("R1 done", done, 0);
    check_buckets("R1 buckets");
  endtask

  task automatic t_distinct();
    do_reset();
    for (int i = 1; i < NBKT; i++) send(i, 100 + i, i == NBKT - 1);
    idle();
    check("R5 no stall", stalls, 0);
    wait_done("R2 done distinct");
    check_buckets("R2 distinct sums");
  endtask

  task automatic t_burst();
    bit saw_low = 0;
    do_reset();
    for (int i = 0; i < 10; i++) begin
      in_valid = 1; in_digit = 4'd3; in_operand = 32'(MODV - 1 - i); in_last = 0;
      if (!in_ready) saw_low = 1;
      send(3, MODV - 1 - i, 0);
      if (i == 2) send(7, 55, 0);
    end
    check("R8 done low midstream", done, 0);
    send(9, 1, 1);
    idle();
    check("R6 backpressure seen", saw_low, 1);
    wait_done("R6 done burst");
    check_buckets("R4 burst sums");
  endtask

  task automatic t_zero();
    do_reset();
    for (int i = 0; i < 12; i++) send(i % 3 == 0 ? 0 : i, 1000 * i + 7, 0);
    send(0, 999, 1);
    idle();
    wait_done("R3 done zero");
    rd_idx = 0; #0.1;
    check("R3 bucket0 untouched", rd_data, 0);
    check_buckets("R3 sums with zeros");
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 200; i++) begin
      lfsr = step(lfsr);
      send(int'(lfsr[3:0]) & ((i % 4 == 0) ? 1 : 15), longint'(lfsr) % MODV, i == 199);
    end
    idle();
    wait_done("R7 done random");
    check_buckets("R7 random sums");
  endtask

  task automatic t_done_timing();
    bit early = 0;
    do_reset();
    send(5, 7, 1);
    idle();
    for (int k = 1; k < LAT; k++) begin
      @(negedge clk);
      if (done) early = 1;
    end
    check("R8 not early", early, 0);
    @(negedge clk);
    check("R8 done at LAT", done, 1);
    rd_idx = 5; #0.1;
    check("R8 result at LAT", rd_data, 7);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_distinct();
    t_burst();
    t_zero();
    t_random();
    t_done_timing();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule